// File: doc/BRIEF.md
# Power-Down I/O Retention Sequencer

This block sequences pad configuration and I/O retention around low-power entry and exit on a chip whose top logic domain can lose power. A power-down request arrives with a mode code. The sequencer first moves the pad configuration select from the normal bank to the power-down bank. For the modes that remove power from the top domain, it then raises four retention enables together. After that it drops the top-domain power-enable and drives the external reset-out low. It stays there until a wakeup event arrives.

On wakeup the top domain is powered again and the pad select returns to the normal bank. In the following cycle the memory-port retention group (which also covers the reset-out pad) and reset-out are released by hardware. The general-purpose group and the audio group stay held until software writes a release bit in a control register. The SD/MMC group has its own release bit. A release bit reads back as 1 once it has taken effect, and stays at 1 until the next power-down entry. Modes that keep the top domain powered only swap the pad bank and wait for wakeup.

Top module: `pdn_ret_seq`

## Requirements
- R1: While reset is low, and for as long as the internal synchronized reset lags, the outputs are: pad_sel_pdn=0, all four retention enables 0, top_pwr_en=1, rst_out_n=1, nand_pad_in=0, sw_rd_data=0. Asserting rst_n takes effect asynchronously, even in the middle of a sequence.
- R2: A pd_req seen while idle latches pd_mode. The clock edge that samples it sets pad_sel_pdn=1. For the top-off modes (pd_mode 2 deep-idle top-off, 4 deep-stop top-off, 5 sleep), the next edge raises ret_grp0, ret_grp1, ret_audio and ret_sdmmc together. The pad bank is therefore already switched for one cycle when retention asserts.
- R3: One edge after the retention enables rise, top_pwr_en goes to 0, rst_out_n goes to 0 and nand_pad_in goes to 1. This holds, with all retention enabled, until the edge that samples wake_evt=1.
- R4: The edge that samples wake_evt in the power-off state sets top_pwr_en=1 (pad bank still power-down, reset-out still low). The next edge sets pad_sel_pdn=0. The edge after that drops ret_grp0 and returns rst_out_n to 1, while ret_grp1, ret_audio and ret_sdmmc stay high.
- R5: Once the block is back in idle, a write (sw_wr_en=1) with bit 31 of sw_wr_data set clears ret_grp1 and ret_audio together at the next edge. A write with bit 22 set clears ret_sdmmc. Each release is independent of the other.
- R6: A release bit is accepted only in idle and only while its group is held. Writes in any other state have no effect, and so do writes while the group is not held. An accepted release shows in sw_rd_data at the same bit position, 31 or 22, and stays 1 until the next pd_req is accepted. All other bits of sw_rd_data read 0.
- R7: For pd_mode 0 (stop), 1 (deep-idle top-on), 3 (deep-stop top-on) and the unused codes 6 and 7, the block sets pad_sel_pdn=1 and waits for wake_evt. No retention enable rises, and top_pwr_en and rst_out_n stay 1. The edge that samples wake_evt sets pad_sel_pdn=0, and the next edge returns the block to idle.
- R8: pd_mode and pd_req are sampled only while idle. wake_evt is sampled only in the power-off state, and, for top-on modes, in the switched state. Changing these inputs at any other time does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Power-down request, sampled while idle |
| pd_mode | input | 3 | Requested low-power mode code |
| wake_evt | input | 1 | Wakeup event |
| sw_wr_en | input | 1 | Control-register write strobe |
| sw_wr_data | input | 32 | Control-register write data (bit 31 main release, bit 22 SD/MMC release) |
| sw_rd_data | output | 32 | Control-register read-back of the sticky release bits |
| pad_sel_pdn | output | 1 | 1 selects the power-down pad configuration bank |
| ret_grp0 | output | 1 | Memory-port and reset-out retention enable |
| ret_grp1 | output | 1 | General-purpose pad retention enable |
| ret_audio | output | 1 | Low-power audio pad retention enable |
| ret_sdmmc | output | 1 | SD/MMC pad retention enable |
| top_pwr_en | output | 1 | Top-domain power enable, 0 requests power-off |
| rst_out_n | output | 1 | External reset-out, active low |
| nand_pad_in | output | 1 | Forces the off-domain NAND-mode pads to input with no pull |

## Verification
The hardest situation to reach from the ports is a release write that arrives while the block is still waking up. The write has to be ignored even though the group is held, and then the same write must be accepted a few cycles later in idle. The stimulus table places a write of both release bits on the cycle the block sits in its wake state and checks that nothing changes. It then repeats the write in idle and checks that only the addressed group drops. The table also changes pd_mode, holds wake_evt high and re-raises pd_req in the middle of a top-off entry, to show that the latched mode alone steers the sequence. A final directed test applies reset during power-off.

// File: rtl/pdn_ret_pkg.sv
package pdn_ret_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    ST_RUN          = 3'd0,
    ST_SWITCH_PDN   = 3'd1,
    ST_ASSERT_RET   = 3'd2,
    ST_POWER_OFF    = 3'd3,
    ST_WAKE         = 3'd4,
    ST_RESTORE_NORM = 3'd5
  } seq_state_e;

  // Mode codes that remove power from the top domain
  localparam logic [MODE_W-1:0] MODE_DIDLE_TOPOFF = 3'd2;
  localparam logic [MODE_W-1:0] MODE_DSTOP_TOPOFF = 3'd4;
  localparam logic [MODE_W-1:0] MODE_SLEEP        = 3'd5;

  function automatic logic mode_cuts_top(input logic [MODE_W-1:0] m);
    return (m == MODE_DIDLE_TOPOFF) || (m == MODE_DSTOP_TOPOFF) || (m == MODE_SLEEP);
  endfunction

endpackage

// File: rtl/pdn_ret_fsm.sv
module pdn_ret_fsm
  import pdn_ret_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic [MODE_W-1:0] pd_mode,
  input  logic              wake_evt,
  output seq_state_e        state_q,
  output logic              topoff_q,
  output logic              enter_pdn,
  output logic              arm_ret
);

  seq_state_e state_d;

  assign enter_pdn = (state_q == ST_RUN) && pd_req;
  assign arm_ret   = (state_q == ST_SWITCH_PDN) && topoff_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:          if (pd_req) state_d = ST_SWITCH_PDN;
      ST_SWITCH_PDN: begin
        if (topoff_q)      state_d = ST_ASSERT_RET;
        else if (wake_evt) state_d = ST_RESTORE_NORM;
      end
      ST_ASSERT_RET:   state_d = ST_POWER_OFF;
      ST_POWER_OFF:    if (wake_evt) state_d = ST_WAKE;
      ST_WAKE:         state_d = ST_RESTORE_NORM;
      ST_RESTORE_NORM: state_d = ST_RUN;
      default:         state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // Mode class latched once per entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         topoff_q <= 1'b0;
    else if (enter_pdn) topoff_q <= mode_cuts_top(pd_mode);
  end

endmodule

// File: rtl/pdn_ret_release.sv
module pdn_ret_release #(
  parameter int REG_W    = 32,
  parameter int MAIN_BIT = 31,
  parameter int SD_BIT   = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_ret,
  input  logic             enter_pdn,
  input  logic             wr_ok,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [1:0]       hold_q,
  output logic [REG_W-1:0] rd_data
);

  localparam int NCH = 2;

  function automatic int chan_pos(input int ch);
    return (ch == 0) ? MAIN_BIT : SD_BIT;
  endfunction

  logic [NCH-1:0] rel_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int POS = chan_pos(c);
    logic accept, en, hold_d, rel_d;

    assign accept = wr_en && wr_ok && wr_data[POS] && hold_q[c];
    assign en     = arm_ret || enter_pdn || accept;

    always_comb begin
      hold_d = hold_q[c];
      rel_d  = rel_q[c];
      if (enter_pdn) rel_d = 1'b0;
      if (arm_ret)   hold_d = 1'b1;
      if (accept) begin
        hold_d = 1'b0;
        rel_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[c] <= 1'b0;
        rel_q[c]  <= 1'b0;
      end else if (en) begin
        hold_q[c] <= hold_d;
        rel_q[c]  <= rel_d;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) rd_data[chan_pos(c)] = rel_q[c];
  end

endmodule

// File: rtl/pdn_ret_seq.sv
module pdn_ret_seq
  import pdn_ret_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int MAIN_BIT    = 31,
  parameter int SD_BIT      = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic [MODE_W-1:0] pd_mode,
  input  logic              wake_evt,
  input  logic              sw_wr_en,
  input  logic [REG_W-1:0]  sw_wr_data,
  output logic [REG_W-1:0]  sw_rd_data,
  output logic              pad_sel_pdn,
  output logic              ret_grp0,
  output logic              ret_grp1,
  output logic              ret_audio,
  output logic              ret_sdmmc,
  output logic              top_pwr_en,
  output logic              rst_out_n,
  output logic              nand_pad_in
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  seq_state_e state_q;
  logic       topoff_q, enter_pdn, arm_ret;
  logic [1:0] hold_q;

  pdn_ret_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pd_req   (pd_req),
    .pd_mode  (pd_mode),
    .wake_evt (wake_evt),
    .state_q  (state_q),
    .topoff_q (topoff_q),
    .enter_pdn(enter_pdn),
    .arm_ret  (arm_ret)
  );

  pdn_ret_release #(
    .REG_W   (REG_W),
    .MAIN_BIT(MAIN_BIT),
    .SD_BIT  (SD_BIT)
  ) u_rel (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .arm_ret  (arm_ret),
    .enter_pdn(enter_pdn),
    .wr_ok    (state_q == ST_RUN),
    .wr_en    (sw_wr_en),
    .wr_data  (sw_wr_data),
    .hold_q   (hold_q),
    .rd_data  (sw_rd_data)
  );

  logic restore_off;
  assign restore_off = (state_q == ST_RESTORE_NORM) && topoff_q;

  assign pad_sel_pdn = (state_q == ST_SWITCH_PDN) || (state_q == ST_ASSERT_RET) ||
                       (state_q == ST_POWER_OFF)  || (state_q == ST_WAKE);
  assign ret_grp0    = (state_q == ST_ASSERT_RET) || (state_q == ST_POWER_OFF) ||
                       (state_q == ST_WAKE) || restore_off;
  assign ret_grp1    = hold_q[0];
  assign ret_audio   = hold_q[0];
  assign ret_sdmmc   = hold_q[1];
  assign top_pwr_en  = (state_q != ST_POWER_OFF);
  assign rst_out_n   = !((state_q == ST_POWER_OFF) || (state_q == ST_WAKE) || restore_off);
  assign nand_pad_in = (state_q == ST_POWER_OFF);

endmodule

// File: rtl/pdn_ret_chk.sv
module pdn_ret_chk (
  input logic clk,
  input logic rst_n,
  input logic pad_sel_pdn,
  input logic ret_grp0,
  input logic ret_grp1,
  input logic ret_audio,
  input logic ret_sdmmc,
  input logic top_pwr_en,
  input logic rst_out_n
);

  // R2
  ret_after_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_grp0) |-> $past(pad_sel_pdn) && ret_grp1 && ret_audio && ret_sdmmc);

  // R3
  pwr_off_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !top_pwr_en |-> pad_sel_pdn && ret_grp0 && ret_grp1 && ret_audio && ret_sdmmc && !rst_out_n);

  // R3
  rstout_in_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> ret_grp0);

  // R4
  grp0_rel_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ret_grp0) |-> !pad_sel_pdn && $past(!pad_sel_pdn));

  // R5
  grp1_rel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ret_grp1) |-> !ret_grp0 && !pad_sel_pdn);

  // R5
  sd_rel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ret_sdmmc) |-> !ret_grp0 && !pad_sel_pdn);

  // R5
  audio_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_grp1 == ret_audio);

endmodule

bind pdn_ret_seq pdn_ret_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pad_sel_pdn(pad_sel_pdn),
  .ret_grp0   (ret_grp0),
  .ret_grp1   (ret_grp1),
  .ret_audio  (ret_audio),
  .ret_sdmmc  (ret_sdmmc),
  .top_pwr_en (top_pwr_en),
  .rst_out_n  (rst_out_n)
);

// File: tb/pdn_ret_seq_tb_top.sv
module pdn_ret_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pd_req, wake_evt, sw_wr_en;
  logic [2:0]  pd_mode;
  logic [31:0] sw_wr_data, sw_rd_data;
  logic        pad_sel_pdn, ret_grp0, ret_grp1, ret_audio, ret_sdmmc;
  logic        top_pwr_en, rst_out_n, nand_pad_in;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pdn_ret_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pd_mode(pd_mode),
    .wake_evt(wake_evt), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .pad_sel_pdn(pad_sel_pdn), .ret_grp0(ret_grp0),
    .ret_grp1(ret_grp1), .ret_audio(ret_audio), .ret_sdmmc(ret_sdmmc),
    .top_pwr_en(top_pwr_en), .rst_out_n(rst_out_n), .nand_pad_in(nand_pad_in)
  );

  // Expected field order: pad, ret0, ret1, audio, sd, pwr, rst_out_n, nand, rd[31], rd[22]
  typedef struct packed {
    logic [3:0] req;
    logic       rq;
    logic [2:0] md;
    logic       wk;
    logic       wr;
    logic       wm;
    logic       ws;
    logic [9:0] ex;
  } vec_t;

  localparam int NV = 24;
  localparam logic [9:0] IDLE0 = 10'b0000011000;

  localparam vec_t TBL [NV] = '{
    '{4'd2, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1000011000}, // R2 sleep entry, bank switched
    '{4'd2, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1111111000}, // R2 all four retain
    '{4'd3, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1111100100}, // R3 power off
    '{4'd3, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1111100100}, // R3 held without wake
    '{4'd4, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 10'b1111110000}, // R4 wake, power on
    '{4'd6, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 10'b0111110000}, // R6 write in wake ignored
    '{4'd4, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0011111000}, // R4 grp0 and reset-out freed
    '{4'd5, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 10'b0000111010}, // R5 bit31 release
    '{4'd6, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 10'b0000111010}, // R6 repeat has no effect
    '{4'd5, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 10'b0000011011}, // R5 bit22 release
    '{4'd6, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0000011011}, // R6 sticky read-back
    '{4'd7, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1000011000}, // R7 top-on entry, R6 bits cleared
    '{4'd7, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1000011000}, // R7 waits for wake
    '{4'd7, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 10'b0000011000}, // R7 restore
    '{4'd7, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0000011000}, // R7 idle
    '{4'd6, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 10'b0000011000}, // R6 write with nothing held
    '{4'd2, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 10'b1000011000}, // R2 deep-stop top-off entry
    '{4'd8, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 10'b1111111000}, // R8 mode change and wake ignored
    '{4'd8, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 10'b1111100100}, // R8 req and wake ignored
    '{4'd4, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 10'b1111110000}, // R4 wake
    '{4'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0111110000}, // R4 normal bank first
    '{4'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'b0011111000}, // R4 idle, groups held
    '{4'd5, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 10'b0011011001}, // R5 SD/MMC alone
    '{4'd5, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 10'b0000011011}  // R5 main group after
  };

  function automatic logic [9:0] observe();
    return {pad_sel_pdn, ret_grp0, ret_grp1, ret_audio, ret_sdmmc,
            top_pwr_en, rst_out_n, nand_pad_in, sw_rd_data[31], sw_rd_data[22]};
  endfunction

  task automatic check(input int rq, input string what, input logic [9:0] exp);
    logic [9:0]  act;
    logic [31:0] exp_rd;
    act    = observe();
    exp_rd = ({31'd0, exp[1]} << 31) | ({31'd0, exp[0]} << 22);
    n_checks++;
    if (act !== exp || sw_rd_data !== exp_rd) begin
      n_errors++;
      $display("FAIL R%0d %s: outputs %b rd %h, expected %b rd %h",
               rq, what, act, sw_rd_data, exp, exp_rd);
    end
  endtask

  task automatic drive(input logic rq, input logic [2:0] md, input logic wk,
                       input logic wr, input logic wm, input logic ws);
    pd_req     = rq;
    pd_mode    = md;
    wake_evt   = wk;
    sw_wr_en   = wr;
    sw_wr_data = {wm, 8'd0, ws, 22'd0};
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(1, "in reset", IDLE0);                     // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, "after reset release", IDLE0);          // R1

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].rq, TBL[i].md, TBL[i].wk, TBL[i].wr, TBL[i].wm, TBL[i].ws);
      @(negedge clk);
      check(int'(TBL[i].req), $sformatf("vector %0d", i), TBL[i].ex);
    end

    // R7: unused mode code 6 behaves as top-on
    drive(1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check(7, "code 6 waits without retention", 10'b1000011000);
    drive(1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(7, "code 6 back to idle", IDLE0);

    // R1: reset applied during power-off of deep-idle top-off
    drive(1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check(3, "deep-idle top-off powered off", 10'b1111100100);
    #2 rst_n = 1'b0;
    #1 check(1, "async reset mid sequence", IDLE0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, "idle after mid-sequence reset", IDLE0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule